// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block runs the fetch half of a small accumulator machine with 5-bit words and 5-bit addresses. A six-stage one-hot ring steps through the fetch. Odd stages put the program counter on the address bus and write one instruction register from the memory read data. Even stages increment the program counter. The opcode fetched in the first stage sets the instruction length. One-word instructions stop the ring after stage two. Most instructions stop it after stage four. Conditional jumps run all six stages.

When fetch ends, the sequencer raises `exec_go` and holds the ring at stage one with every strobe low until the execute sequencer pulses `exec_done`. Memory is read combinationally: `mem_rdata` must reflect `addr_bus` in the same cycle. Opcode codes, 5 bits: HALT 00000, INC 00001, NOT 00010, AND 01000, OR 01001, XOR 01010, SUB 01011, ADD 01100, LOAD 01101, STOR 01110, JMP 10000, JEQ 10001, JNE 10010, JLE 10011, JLT 10100, JGE 10101, JGT 10110.

Top module: `insn_fetch_seq`

## Requirements
- R1: `fetch_phase` is one-hot at all times, with bit 0 as stage one. Reset loads 000001. During fetch the set bit moves up one position per clock, and the first fetch cycle of every instruction is stage one.
- R2: While `rst_n` is low, every strobe is 0, `exec_go` is 0, and `pc`, `opcode`, `operand_addr` and `jump_addr` are 0. The first stage-one cycle is the second clock cycle after reset is released.
- R3: In stages one, three and five, `addr_drive` is 1 and `addr_bus` equals `pc`. In all other cycles `addr_bus` is 0. In stages two, four and six, `pc_inc` is 1 and `pc` becomes `pc`+1 at the end of the cycle.
- R4: In stage one, `opc_wr` is 1 and `opcode` captures `mem_rdata`.
- R5: For HALT (00000), INC (00001) and NOT (00010), fetch ends after stage two: 2 strobe cycles, one word.
- R6: In stage three, the word goes to `jump_addr` for JMP (10000) and to `operand_addr` for every other opcode. Fetch ends after stage four unless the opcode is a conditional jump.
- R7: For the conditional jumps JEQ 10001, JNE 10010, JLE 10011, JLT 10100, JGE 10101 and JGT 10110, stages five and six load the third word into `jump_addr` and increment `pc`: 6 strobe cycles.
- R8: An instruction register that is not written during a fetch keeps its previous value.
- R9: `exec_go` rises on the clock after the last fetch stage. While it is 1, all strobes are 0 and `fetch_phase` is 000001. A cycle with `exec_done` high clears `exec_go`, and the following cycle is stage one of the next fetch.
- R10: `exec_done` is ignored while `exec_go` is 0. It neither shortens nor changes a fetch.
- R11: The program counter wraps from 11111 to 00000, with the carry dropped.
- R12: All strobes are registered. `addr_drive` and `pc_inc` are never 1 together. Exactly one of `opc_wr`, `opr_wr` and `jmp_wr` is 1 when `addr_drive` is 1, and none of them otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | W | Memory read data for `addr_bus` |
| exec_done | input | 1 | Execute hands control back to fetch |
| addr_bus | output | W | Gated program counter, 0 when not driven |
| addr_drive | output | 1 | Program counter drives the address bus |
| pc_inc | output | 1 | Program counter increment strobe |
| opc_wr | output | 1 | Opcode register write strobe |
| opr_wr | output | 1 | Operand-address register write strobe |
| jmp_wr | output | 1 | Jump-address register write strobe |
| exec_go | output | 1 | Fetch complete, execute owns the machine |
| fetch_phase | output | 6 | One-hot ring state, bit 0 is stage one |
| pc | output | W | Program counter |
| opcode | output | W | Opcode register |
| operand_addr | output | W | Operand-address register |
| jump_addr | output | W | Jump-address register |

## Verification
Every cycle, the embedded properties check that the ring stays one-hot, that drive and increment strobes never overlap, that write strobes occur only with address drive, and that no strobe fires during execute or reset. They also check that each increment adds exactly one and that `exec_go` holds until `exec_done`. Only the bench scenarios can show that instruction length follows the opcode class, that each word lands in the correct register while the others hold, that the address sequence is correct, and that a fetch straddling address 1F wraps. The bench also shows that stray `exec_done` pulses during fetch change nothing.

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mem_rdata,
  input  logic         exec_done,
  output logic [W-1:0] addr_bus,
  output logic         addr_drive,
  output logic         pc_inc,
  output logic         opc_wr,
  output logic         opr_wr,
  output logic         jmp_wr,
  output logic         exec_go,
  output logic [5:0]   fetch_phase,
  output logic [W-1:0] pc,
  output logic [W-1:0] opcode,
  output logic [W-1:0] operand_addr,
  output logic [W-1:0] jump_addr
);
  localparam logic [5:0] STAGE1  = 6'b000001;
  localparam logic [4:0] OP_HALT = 5'b00000;
  localparam logic [4:0] OP_INC  = 5'b00001;
  localparam logic [4:0] OP_NOT  = 5'b00010;
  localparam logic [4:0] OP_JMP  = 5'b10000;
  localparam logic [4:0] OP_JEQ  = 5'b10001;
  localparam logic [4:0] OP_JNE  = 5'b10010;
  localparam logic [4:0] OP_JLE  = 5'b10011;
  localparam logic [4:0] OP_JLT  = 5'b10100;
  localparam logic [4:0] OP_JGE  = 5'b10101;
  localparam logic [4:0] OP_JGT  = 5'b10110;

  logic       run_q, run_n, go_n;
  logic [5:0] phase_n;
  logic [4:0] op;
  logic       one_word, is_jmp, cond_jmp, fetch_last;

  assign op       = opcode[4:0];
  assign one_word = (op == OP_HALT) || (op == OP_INC) || (op == OP_NOT);
  assign is_jmp   = (op == OP_JMP);
  assign cond_jmp = op inside {OP_JEQ, OP_JNE, OP_JLE, OP_JLT, OP_JGE, OP_JGT};
  assign fetch_last = (fetch_phase[1] & one_word) | (fetch_phase[3] & ~cond_jmp) | fetch_phase[5];
  assign addr_bus = addr_drive ? pc : '0;

  always_comb begin
    phase_n = fetch_phase;
    run_n   = run_q;
    go_n    = exec_go;
    if (run_q) begin
      if (fetch_last) begin
        phase_n = STAGE1;
        run_n   = 1'b0;
        go_n    = 1'b1;
      end else begin
        phase_n = {fetch_phase[4:0], fetch_phase[5]};
      end
    end else if (exec_go) begin
      if (exec_done) begin
        run_n = 1'b1;
        go_n  = 1'b0;
      end
    end else begin
      run_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_phase <= STAGE1;
      run_q       <= 1'b0;
      exec_go     <= 1'b0;
      addr_drive  <= 1'b0;
      pc_inc      <= 1'b0;
      opc_wr      <= 1'b0;
      opr_wr      <= 1'b0;
      jmp_wr      <= 1'b0;
    end else begin
      fetch_phase <= phase_n;
      run_q       <= run_n;
      exec_go     <= go_n;
      addr_drive  <= run_n & (phase_n[0] | phase_n[2] | phase_n[4]);
      pc_inc      <= run_n & (phase_n[1] | phase_n[3] | phase_n[5]);
      opc_wr      <= run_n & phase_n[0];
      opr_wr      <= run_n & phase_n[2] & ~is_jmp;
      jmp_wr      <= run_n & ((phase_n[2] & is_jmp) | phase_n[4]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc           <= '0;
      opcode       <= '0;
      operand_addr <= '0;
      jump_addr    <= '0;
    end else begin
      if (pc_inc) pc <= pc + 1'b1;
      if (opc_wr) opcode <= mem_rdata;
      if (opr_wr) operand_addr <= mem_rdata;
      if (jmp_wr) jump_addr <= mem_rdata;
    end
  end

  // R1
  ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fetch_phase) == 1);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_drive && pc_inc));

  // R12
  wr_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({opc_wr, opr_wr, jmp_wr}) == (addr_drive ? 1 : 0));

  // R9
  exec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> (!addr_drive && !pc_inc && fetch_phase == STAGE1));

  // R9
  exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_go && !exec_done) |=> exec_go);

  // R11
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |=> (pc == $past(pc) + 1'b1));

  // R2
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!opc_wr && !opr_wr && !jmp_wr && !pc_inc && !exec_go);
    end
  end
endmodule

// File: tb/insn_fetch_seq_tb_top.sv
module insn_fetch_seq_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_done = 1'b0;
  logic [4:0] mem_rdata, addr_bus, pc, opcode, operand_addr, jump_addr;
  logic       addr_drive, pc_inc, opc_wr, opr_wr, jmp_wr, exec_go;
  logic [5:0] fetch_phase;
  logic [4:0] mem [32];
  logic [4:0] exp_pc;
  int nchk = 0;
  int nerr = 0;

  always #(CLK_P/2) clk = ~clk;
  assign mem_rdata = mem[addr_bus];

  insn_fetch_seq #(.W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .exec_done(exec_done),
    .addr_bus(addr_bus), .addr_drive(addr_drive), .pc_inc(pc_inc),
    .opc_wr(opc_wr), .opr_wr(opr_wr), .jmp_wr(jmp_wr), .exec_go(exec_go),
    .fetch_phase(fetch_phase), .pc(pc), .opcode(opcode),
    .operand_addr(operand_addr), .jump_addr(jump_addr)
  );

  function automatic int words_of(logic [4:0] op);
    if (op <= 5'd2) return 1;
    if (op >= 5'd17 && op <= 5'd22) return 3;
    return 2;
  endfunction

  function automatic logic [4:0] pick_code(int k);
    case (k)
      0: return 5'b00000;  1: return 5'b00001;  2: return 5'b00010;
      3: return 5'b01000;  4: return 5'b01001;  5: return 5'b01010;
      6: return 5'b01011;  7: return 5'b01100;  8: return 5'b01101;
      9: return 5'b01110;  10: return 5'b10000; 11: return 5'b10001;
      12: return 5'b10010; 13: return 5'b10011; 14: return 5'b10100;
      15: return 5'b10101; default: return 5'b10110;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    exec_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(fetch_phase == 6'b000001, "R1", "phase in reset", fetch_phase, 1);
    chk({addr_drive, pc_inc, opc_wr, opr_wr, jmp_wr, exec_go} == 6'b0, "R2", "strobes in reset",
        {addr_drive, pc_inc, opc_wr, opr_wr, jmp_wr, exec_go}, 0);
    chk(pc == 0 && opcode == 0 && operand_addr == 0 && jump_addr == 0, "R2", "regs in reset",
        {pc, opcode, operand_addr, jump_addr}, 0);
    rst_n = 1'b1;
    exp_pc = 5'd0;
  endtask

  task automatic run_instr(input bit inject);
    logic [4:0] pc0, op, prev_opr, prev_jmp;
    int n, k, drv, inj_at;
    bit seen_go;
    string lreq;
    pc0 = exp_pc;
    op = mem[pc0];
    n = words_of(op);
    prev_opr = operand_addr;
    prev_jmp = jump_addr;
    k = 0; drv = 0; seen_go = 1'b0;
    inj_at = inject ? int'($urandom_range(0, 2*n - 1)) : -1;
    for (int c = 0; c < 20 && !seen_go; c++) begin
      @(negedge clk);
      exec_done = 1'b0;
      if (exec_go) seen_go = 1'b1;
      else if (addr_drive || pc_inc) begin
        chk(k < 6 && fetch_phase == 6'(1 << k), "R1", "phase order", fetch_phase, 1 << k);
        chk(!(addr_drive && pc_inc), "R12", "drive/inc overlap", {addr_drive, pc_inc}, 0);
        chk($countones({opc_wr, opr_wr, jmp_wr}) == (addr_drive ? 1 : 0), "R12", "write strobe count",
            $countones({opc_wr, opr_wr, jmp_wr}), addr_drive ? 1 : 0);
        if (k % 2 == 0) begin
          chk(addr_drive && addr_bus == 5'(pc0 + drv), "R3", "address on bus", addr_bus, 5'(pc0 + drv));
          if (k == 0) chk(opc_wr, "R4", "opcode strobe", opc_wr, 1);
          drv++;
        end else begin
          chk(pc_inc && addr_bus == 5'd0, "R3", "bus idle on increment", addr_bus, 0);
        end
        if (k == inj_at) exec_done = 1'b1;
        k++;
      end
    end
    chk(seen_go, "R9", "exec_go after fetch", seen_go, 1);
    lreq = (n == 1) ? "R5" : (n == 2) ? "R6" : "R7";
    chk(k == 2*n, lreq, inject ? "fetch length with stray done R10" : "fetch length", k, 2*n);
    chk(opcode == op, "R4", "opcode register", opcode, op);
    if (n == 1) begin
      chk(operand_addr == prev_opr && jump_addr == prev_jmp, "R8", "regs held one-word",
          {operand_addr, jump_addr}, {prev_opr, prev_jmp});
    end else if (n == 2 && op == 5'b10000) begin
      chk(jump_addr == mem[5'(pc0 + 1)], "R6", "jmp target", jump_addr, mem[5'(pc0 + 1)]);
      chk(operand_addr == prev_opr, "R8", "operand held on jmp", operand_addr, prev_opr);
    end else if (n == 2) begin
      chk(operand_addr == mem[5'(pc0 + 1)], "R6", "operand", operand_addr, mem[5'(pc0 + 1)]);
      chk(jump_addr == prev_jmp, "R8", "jump held", jump_addr, prev_jmp);
    end else begin
      chk(operand_addr == mem[5'(pc0 + 1)], "R7", "cond operand", operand_addr, mem[5'(pc0 + 1)]);
      chk(jump_addr == mem[5'(pc0 + 2)], "R7", "cond target", jump_addr, mem[5'(pc0 + 2)]);
    end
    exp_pc = 5'(pc0 + n);
    chk(pc == exp_pc, (int'(pc0) + n > 31) ? "R11" : "R3", "pc after fetch", pc, exp_pc);
    repeat ($urandom_range(0, 4)) begin
      @(negedge clk);
      chk(exec_go && !addr_drive && !pc_inc && fetch_phase == 6'b000001, "R9", "execute hold",
          {exec_go, addr_drive, pc_inc}, 4);
    end
    exec_done = 1'b1;
  endtask

  initial begin
    #(CLK_P * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) mem[i] = 5'b00010;
    mem[30] = 5'b10100;
    mem[31] = 5'b00111;
    do_reset();
    for (int i = 0; i < 31; i++) run_instr(1'b0);
    chk(exp_pc == 5'd1 && pc == 5'd1, "R11", "wrap across 1F", pc, 1);
    chk(operand_addr == 5'd7 && jump_addr == 5'd2, "R11", "words across wrap",
        {operand_addr, jump_addr}, {5'd7, 5'd2});
    run_instr(1'b1);
    for (int i = 0; i < 32; i++) mem[i] = pick_code($urandom_range(0, 16));
    do_reset();
    for (int i = 0; i < 200; i++) run_instr(1'($urandom_range(0, 1)));
    @(negedge clk);
    exec_done = 1'b0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule